// File: doc/BRIEF.md
# I2C Bus Lockup Recovery Timer

This block sits next to an I2C target front end and watches the shared data line. If the target keeps SDA low for too long while it is in a transfer, the block sends a one-cycle bus-reset pulse. That pulse sends the front end back to waiting for a start condition. In the same cycle the pulse blanks the target's SDA output enable, so the line is released even if the front end is wedged.

The block also turns each stop condition on the bus into a bus-reset pulse. This covers the usual recovery sequence, where the controller clocks a stuck target free and then issues a stop.

An active-low reset pin is synchronized and filtered by pulse width. A low pulse that is long enough produces one pulse that resets both the bus logic and the register file. Parameters can remove the timeout or the reset pin for variants that lack them.

SCL, SDA and the reset pin are sampled through two-flop synchronizers. All timing below counts edges of the block clock. The timeout is a clock-count parameter, so it can be set to match 250 ms at the real clock rate.

Top module: `i2c_lockup_guard`

## Requirements
- R1: After `rst_n` is released, `bus_reset` and `regs_reset` are 0.
- R2: `sda_oe` equals `tgt_sda_oe` in every cycle except a cycle where `bus_reset` is 1. In that cycle `sda_oe` is 0.
- R3: `sda_in` may fall in the cycle after clock edge N. If it then stays low and `tgt_busy` stays 1, `bus_reset` is 1 for exactly the cycle after edge N+2+TIMEOUT_CYCLES, with `regs_reset` 0.
- R4: A high level on synchronized SDA clears the timeout count. A low stretch shorter than TIMEOUT_CYCLES, followed by a high, gives no pulse. The next low stretch is timed from zero.
- R5: While `tgt_busy` is 0 the timeout count does not advance, so SDA held low for any length of time gives no pulse.
- R6: A stop condition is SDA rising while SCL is high. If SDA rises after edge N with SCL already high, `bus_reset` is 1 for the cycle after edge N+3, with `regs_reset` 0.
- R7: `ext_rst_n` may go low after edge N and stay low for at least RST_MIN_CYCLES cycles. Then `bus_reset` and `regs_reset` are both 1 for the single cycle after edge N+2+RST_MIN_CYCLES. This happens only once per low pulse, however long the pulse is.
- R8: A low pulse on `ext_rst_n` shorter than RST_MIN_CYCLES cycles gives no pulse.
- R9: With HAS_TIMEOUT=0 and HAS_RST_PIN=0, neither a long SDA low nor a reset-pin pulse gives a pulse. Stop conditions still give a pulse.
- R10: `bus_reset` and `regs_reset` never stay high for two cycles in a row when their triggers are separated. `regs_reset` is only ever high together with `bus_reset`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running block clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| scl_in | input | 1 | SCL line level, asynchronous |
| sda_in | input | 1 | SDA line level, asynchronous |
| ext_rst_n | input | 1 | Active-low external reset pin, asynchronous |
| tgt_busy | input | 1 | Target front end is outside its idle state |
| tgt_sda_oe | input | 1 | Target request to pull SDA low |
| sda_oe | output | 1 | Gated SDA pull-down enable to the pad |
| bus_reset | output | 1 | One-cycle reset pulse to the target front end |
| regs_reset | output | 1 | One-cycle reset pulse to the register file |

## Verification
Most faults inside the block show up as a bus-reset pulse in the wrong cycle. A timeout count that is off by one, or that fails to clear when SDA goes high, moves the pulse a cycle or more from N+2+TIMEOUT_CYCLES, or produces a pulse where none is due. A broken width filter on the reset pin either ignores a valid pulse or lets a short one through, visible within a few cycles of the pin returning high. A stuck counter or a missing gate appears as a pulse that lasts two or more cycles, or as `sda_oe` still asserted during the reset cycle. Every pulse is therefore compared against its predicted cycle, and any pulse the scoreboard does not expect is an error.

// File: rtl/i2c_lockup_guard.sv
module i2c_lockup_guard #(
  parameter int unsigned TIMEOUT_CYCLES = 25_000_000,
  parameter int unsigned RST_MIN_CYCLES = 100,
  parameter bit          HAS_TIMEOUT    = 1'b1,
  parameter bit          HAS_RST_PIN    = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic ext_rst_n,
  input  logic tgt_busy,
  input  logic tgt_sda_oe,
  output logic sda_oe,
  output logic bus_reset,
  output logic regs_reset
);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
  localparam int RW = $clog2(RST_MIN_CYCLES + 1);

  logic [1:0] scl_sy, sda_sy;
  logic       sda_q;
  logic       scl_s, sda_s;
  logic       stop_det, to_fire, pin_fire;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      sda_q  <= sda_sy[1];
    end

  assign scl_s    = scl_sy[1];
  assign sda_s    = sda_sy[1];
  assign stop_det = scl_s & sda_s & ~sda_q;

  generate
    if (HAS_TIMEOUT) begin : g_timeout
      logic [TW-1:0] to_cnt;
      logic          to_hit;
      assign to_hit  = (to_cnt == TW'(TIMEOUT_CYCLES - 1));
      assign to_fire = ~sda_s & tgt_busy & to_hit;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)        to_cnt <= '0;
        else if (sda_s)    to_cnt <= '0;
        else if (tgt_busy) to_cnt <= to_hit ? '0 : to_cnt + 1'b1;
    end else begin : g_no_timeout
      logic busy_unused;
      assign busy_unused = tgt_busy;
      assign to_fire     = 1'b0;
    end

    if (HAS_RST_PIN) begin : g_pin
      logic [1:0]    pin_sy;
      logic [RW-1:0] pin_cnt;
      assign pin_fire = ~pin_sy[1] & (pin_cnt == RW'(RST_MIN_CYCLES - 1));
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          pin_sy  <= 2'b11;
          pin_cnt <= '0;
        end else begin
          pin_sy <= {pin_sy[0], ext_rst_n};
          if (pin_sy[1])                            pin_cnt <= '0;
          else if (pin_cnt != RW'(RST_MIN_CYCLES))  pin_cnt <= pin_cnt + 1'b1;
        end
    end else begin : g_no_pin
      logic pin_unused;
      assign pin_unused = ext_rst_n;
      assign pin_fire   = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bus_reset  <= 1'b0;
      regs_reset <= 1'b0;
    end else begin
      bus_reset  <= to_fire | stop_det | pin_fire;
      regs_reset <= pin_fire;
    end

  assign sda_oe = tgt_sda_oe & ~bus_reset;
endmodule

// File: rtl/i2c_lockup_guard_chk.sv
module i2c_lockup_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic tgt_sda_oe,
  input logic sda_oe,
  input logic bus_reset,
  input logic regs_reset
);
  // R2
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |-> !sda_oe);
  // R2
  follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_reset |-> (sda_oe == tgt_sda_oe));
  // R10
  bus_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> !bus_reset);
  // R10
  regs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    regs_reset |=> !regs_reset);
  // R7
  regs_with_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    regs_reset |-> bus_reset);
endmodule

bind i2c_lockup_guard i2c_lockup_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tgt_sda_oe(tgt_sda_oe), .sda_oe(sda_oe),
  .bus_reset(bus_reset), .regs_reset(regs_reset)
);

// File: tb/i2c_lockup_guard_bench.sv
module i2c_lockup_guard_bench;
  localparam int T  = 20;
  localparam int RM = 5;

  logic clk = 1'b0;
  logic rst_n, scl, sda, ext_n, busy, oe;
  logic sda_oe, bus_reset, regs_reset;
  logic m_oe, m_bus, m_regs;
  int cyc = 0, checks = 0, errors = 0, n_pulse = 0, m_pulse = 0;
  bit done = 1'b0;
  int exp_cyc[$];
  bit exp_reg[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  i2c_lockup_guard #(.TIMEOUT_CYCLES(T), .RST_MIN_CYCLES(RM)) u_i2c_lockup_guard (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda), .ext_rst_n(ext_n),
    .tgt_busy(busy), .tgt_sda_oe(oe), .sda_oe(sda_oe),
    .bus_reset(bus_reset), .regs_reset(regs_reset));

  i2c_lockup_guard #(.TIMEOUT_CYCLES(T), .RST_MIN_CYCLES(RM),
                     .HAS_TIMEOUT(1'b0), .HAS_RST_PIN(1'b0)) u_i2c_lockup_guard_min (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda), .ext_rst_n(ext_n),
    .tgt_busy(busy), .tgt_sda_oe(oe), .sda_oe(m_oe),
    .bus_reset(m_bus), .regs_reset(m_regs));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_pulse(input int c, input bit r);
    exp_cyc.push_back(c);
    exp_reg.push_back(r);
  endtask

  always @(negedge clk) if (rst_n) begin
    if (m_bus) m_pulse++;
    if (bus_reset) begin
      n_pulse++;
      chk(sda_oe == 1'b0, "R2 oe blank", int'(sda_oe), 0);
      if (exp_cyc.size() == 0) begin
        chk(1'b0, "R4/R5/R8 unexpected pulse", cyc, -1);
      end else begin
        int c;
        bit r;
        c = exp_cyc.pop_front();
        r = exp_reg.pop_front();
        chk(cyc == c, "R3/R6/R7 pulse cycle", cyc, c);
        chk(regs_reset == r, "R7 regs flag", int'(regs_reset), int'(r));
      end
    end else begin
      chk(regs_reset == 1'b0, "R10 regs alone", int'(regs_reset), 0);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n0;
    rst_n = 1'b0; scl = 1'b1; sda = 1'b1; ext_n = 1'b1; busy = 1'b0; oe = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R1
    chk(bus_reset == 1'b0, "R1 bus_reset", int'(bus_reset), 0);
    chk(regs_reset == 1'b0, "R1 regs_reset", int'(regs_reset), 0);
    chk(sda_oe == 1'b0, "R2 follow low", int'(sda_oe), 0);
    oe = 1'b1;
    tick(1);
    chk(sda_oe == 1'b1, "R2 follow high", int'(sda_oe), 1);

    // R3 timeout
    busy = 1'b1; scl = 1'b0;
    tick(4);
    sda = 1'b0; expect_pulse(cyc + 2 + T, 1'b0);
    tick(T + 6);
    sda = 1'b1;
    tick(5);

    // R4 short low then full low
    sda = 1'b0;
    tick(T - 3);
    sda = 1'b1;
    tick(3);
    sda = 1'b0; expect_pulse(cyc + 2 + T, 1'b0);
    tick(T + 6);
    sda = 1'b1;
    tick(5);

    // R5 idle target
    busy = 1'b0; n0 = n_pulse;
    sda = 1'b0;
    tick(3 * T);
    sda = 1'b1;
    tick(5);
    chk(n_pulse == n0, "R5 no pulse when idle", n_pulse, n0);

    // R6 stop condition
    sda = 1'b0;
    tick(4);
    scl = 1'b1;
    tick(4);
    sda = 1'b1; expect_pulse(cyc + 3, 1'b0);
    tick(8);

    // R7 reset pin, minimum and long pulses
    ext_n = 1'b0; expect_pulse(cyc + 2 + RM, 1'b1);
    tick(RM);
    ext_n = 1'b1;
    tick(8);
    ext_n = 1'b0; expect_pulse(cyc + 2 + RM, 1'b1);
    tick(4 * RM);
    ext_n = 1'b1;
    tick(8);

    // R8 short pin pulse
    n0 = n_pulse;
    ext_n = 1'b0;
    tick(RM - 1);
    ext_n = 1'b1;
    tick(8);
    chk(n_pulse == n0, "R8 short pin pulse ignored", n_pulse, n0);

    // R9 reduced variant: only the stop pulse
    chk(m_pulse == 1, "R9 reduced variant pulses", m_pulse, 1);
    chk(exp_cyc.size() == 0, "R3/R7 missing pulses", exp_cyc.size(), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule